// File: doc/BRIEF.md
# I2C Memory Slave Transaction Engine

This block is the bus-facing half of a byte-addressed serial memory. It watches SCL and SDA on the system clock, after a synchroniser whose depth is a parameter. It recognises START, repeated START and STOP, and steps through the byte and acknowledge phases of an I2C slave. It drives SDA open-drain through a single pull-low enable. It never drives the line high.

Around it sit three other parts: a pointer unit, a write buffer, and an internal write sequencer that reports when a write is in progress. In a write, the engine hands the pointer unit the first byte after the device address. Each following byte goes to the write buffer. A STOP after at least one such data byte tells the sequencer to start the write.

In a read, the engine shifts out the byte the pointer unit presents, most significant bit first. It asks the pointer unit to advance after each byte. It keeps going for as long as the master acknowledges. While the sequencer reports busy, the engine does not acknowledge its own address, so a master can poll for the end of the write.

Top module: `i2c_slave_engine`

## Requirements
- R1: After reset `sda_oe` is 0 and the strobes `ptr_load`, `wbuf_push`, `ptr_inc` and `wr_launch` are all 0.
- R2: A START followed by the 7-bit address equal to `DEV_ADDR` (sent MSB first, then the R/W bit, where 0 means write and 1 means read) is acknowledged by pulling SDA low during the ninth clock. Any other address gets no acknowledge, and the rest of that transaction produces neither acknowledges nor strobes.
- R3: While `busy_i` is 1 at the end of the address byte, the matching address is not acknowledged and the transaction is ignored.
- R4: In a write, the first byte after the address is acknowledged and given out as a one-cycle `ptr_load` pulse with the byte on `ptr_data`.
- R5: In a write, each later byte is acknowledged and given out as a one-cycle `wbuf_push` pulse with the byte on `wbuf_data`. No two strobes are ever high in the same cycle.
- R6: A STOP after a write with at least one data byte gives one `wr_launch` pulse. A STOP after an address-only write, or after a read, gives none.
- R7: In a read, the engine acknowledges the address and then sends `rd_data_i` MSB first. It pulses `ptr_inc` once after each byte it sends.
- R8: A read continues with the next byte when the master acknowledges. After a master no-acknowledge the engine releases SDA and keeps it released until the next START.
- R9: A write carrying only the pointer byte, followed by a repeated START with R/W=1, becomes a read from the new pointer without a STOP in between.
- R10: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_i | input | 1 | Internal write in progress |
| rd_data_i | input | 8 | Byte at the current pointer |
| ptr_load | output | 1 | One-cycle strobe: load pointer from `ptr_data` |
| ptr_data | output | 8 | New pointer value |
| ptr_inc | output | 1 | One-cycle strobe: advance pointer |
| wbuf_push | output | 1 | One-cycle strobe: append `wbuf_data` to the write buffer |
| wbuf_data | output | 8 | Data byte for the write buffer |
| wr_launch | output | 1 | One-cycle strobe: start the internal write |

## Verification
The bench builds the engine with `DEV_ADDR` set to 7'h52 rather than its default. A neighbouring address, which differs from it in bit 0 only, then probes the comparison in its least significant bit. The synchroniser keeps its default depth of two, and each SCL half period lasts ten system clocks. With these values the delay between a bus edge and the engine's response stays well inside one SCL phase. That makes it possible to catch an acknowledge or a data bit that lands one phase early or late.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ACK_AW, ST_ACK_AR, ST_REG, ST_ACK_B,
    ST_WDATA, ST_TX, ST_RACK, ST_IGNORE
  } eng_state_e;

  // Address byte: bits 7..1 device address, bit 0 R/W.
  function automatic logic addr_hit(logic [BYTE_W-1:0] b, logic [6:0] dev, logic busy);
    return (b[BYTE_W-1:1] == dev) && !busy;
  endfunction

  function automatic logic is_ack_state(eng_state_e s);
    return (s == ST_ACK_AW) || (s == ST_ACK_AR) || (s == ST_ACK_B);
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin scl_ff <= '1; sda_ff <= '1; end
        else begin scl_ff <= scl_i; sda_ff <= sda_i; end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin scl_ff <= '1; sda_ff <= '1; end
        else begin
          scl_ff <= {scl_ff[STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[STAGES-2:0], sda_i};
        end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin scl_d <= 1'b1; sda_d <= 1'b1; end
    else begin scl_d <= scl_s; sda_d <= sda_s; end

  assign scl_s    = scl_ff[STAGES-1];
  assign sda_s    = sda_ff[STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_tx_shift.sv
module i2c_tx_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         msb
);
  logic [W-1:0] sr;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     sr <= '1;
    else if (load)  sr <= din;
    else if (shift) sr <= {sr[W-2:0], 1'b1};
  assign msb = sr[W-1];
endmodule

// File: rtl/i2c_slave_engine.sv
module i2c_slave_engine
  import i2c_eng_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              busy_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              ptr_load,
  output logic [BYTE_W-1:0] ptr_data,
  output logic              ptr_inc,
  output logic              wbuf_push,
  output logic [BYTE_W-1:0] wbuf_data,
  output logic              wr_launch
);
  localparam logic [CNT_W-1:0] BITS_LAST = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] TX_LAST   = CNT_W'(BYTE_W - 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  eng_state_e       st;
  logic [CNT_W-1:0] cnt;
  logic [BYTE_W-1:0] rx;
  logic mack, wrote, tx_msb;
  logic byte_done, tx_load, tx_shift;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  assign byte_done = scl_fall && (cnt == BITS_LAST);
  assign tx_load   = scl_fall && ((st == ST_ACK_AR) || (st == ST_RACK && mack));
  assign tx_shift  = scl_fall && (st == ST_TX);

  i2c_tx_shift #(.W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(tx_load), .shift(tx_shift),
    .din(rd_data_i), .msb(tx_msb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; rx <= '0; mack <= 1'b0; wrote <= 1'b0;
      ptr_load <= 1'b0; ptr_data <= '0; ptr_inc <= 1'b0;
      wbuf_push <= 1'b0; wbuf_data <= '0; wr_launch <= 1'b0;
    end else begin
      ptr_load <= 1'b0; ptr_inc <= 1'b0; wbuf_push <= 1'b0; wr_launch <= 1'b0;
      if (start_ev) begin
        st <= ST_ADDR; cnt <= '0;
      end else if (stop_ev) begin
        st <= ST_IDLE; wr_launch <= wrote; wrote <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_REG, ST_WDATA: begin
            if (scl_rise) begin
              rx <= {rx[BYTE_W-2:0], sda_s}; cnt <= cnt + 1'b1;
            end else if (byte_done) begin
              cnt <= '0;
              if (st == ST_ADDR) begin
                if (addr_hit(rx, DEV_ADDR, busy_i)) st <= rx[0] ? ST_ACK_AR : ST_ACK_AW;
                else                                st <= ST_IGNORE;
              end else if (st == ST_REG) begin
                ptr_load <= 1'b1; ptr_data <= rx; st <= ST_ACK_B;
              end else begin
                wbuf_push <= 1'b1; wbuf_data <= rx; wrote <= 1'b1; st <= ST_ACK_B;
              end
            end
          end
          ST_ACK_AW: if (scl_fall) st <= ST_REG;
          ST_ACK_B:  if (scl_fall) st <= ST_WDATA;
          ST_ACK_AR: if (scl_fall) begin st <= ST_TX; cnt <= '0; end
          ST_TX: if (scl_fall) begin
            if (cnt == TX_LAST) begin st <= ST_RACK; ptr_inc <= 1'b1; end
            else cnt <= cnt + 1'b1;
          end
          ST_RACK: begin
            if (scl_rise) mack <= ~sda_s;
            else if (scl_fall) begin cnt <= '0; st <= mack ? ST_TX : ST_IGNORE; end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe = is_ack_state(st) || ((st == ST_TX) && !tx_msb);

  // R10: the line drive only moves during the low phase of SCL
  a_r10_oe_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);
  // R3: a busy write sequencer turns a matching address into a refusal
  a_r3_busy_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ADDR && byte_done && busy_i && !start_ev && !stop_ev) |=> (st == ST_IGNORE));
  // R6: the launch strobe follows a STOP directly
  a_r6_launch_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    wr_launch |-> $past(stop_ev));
  // R5: strobes are mutually exclusive
  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ptr_load, ptr_inc, wbuf_push, wr_launch}));
  // R8: a master no-acknowledge frees the line
  a_r8_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RACK && scl_fall && !mack && !start_ev && !stop_ev) |=> !sda_oe);
endmodule

// File: tb/i2c_slave_engine_tb.sv
module i2c_slave_engine_tb;
  localparam logic [6:0] DEV = 7'h52;
  localparam int H = 10;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, scl_m = 1'b1, sda_m_low = 1'b0, busy = 1'b0;
  logic sda_oe, ptr_load, ptr_inc, wbuf_push, wr_launch;
  logic [7:0] ptr_data, wbuf_data, rd_data, ptr_m;
  wire sda_line = ~(sda_m_low | sda_oe);

  i2c_slave_engine #(.DEV_ADDR(DEV), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .busy_i(busy), .rd_data_i(rd_data), .ptr_load(ptr_load), .ptr_data(ptr_data),
    .ptr_inc(ptr_inc), .wbuf_push(wbuf_push), .wbuf_data(wbuf_data), .wr_launch(wr_launch)
  );

  function automatic logic [7:0] mem_f(logic [7:0] a);
    return (a * 8'd7) ^ 8'h5A;
  endfunction

  always_ff @(posedge clk)
    if (!rst_n)        ptr_m <= 8'h00;
    else if (ptr_load) ptr_m <= ptr_data;
    else if (ptr_inc)  ptr_m <= ptr_m + 8'd1;
  assign rd_data = mem_f(ptr_m);

  int checks = 0, fails = 0, r10_viol = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard: kind 0 ptr_load, 1 wbuf_push, 2 ptr_inc, 3 wr_launch
  typedef struct { int kind; logic [7:0] d; } ev_t;
  ev_t q[$];
  task automatic expect_ev(input int k, input logic [7:0] d);
    ev_t e; e.kind = k; e.d = d; q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (rst_n && (ptr_load | wbuf_push | ptr_inc | wr_launch)) begin
      int k; logic [7:0] d; ev_t e;
      k = ptr_load ? 0 : wbuf_push ? 1 : ptr_inc ? 2 : 3;
      d = ptr_load ? ptr_data : wbuf_push ? wbuf_data : 8'h00;
      if (q.size() == 0) check(1'b0, "R6 unexpected strobe", k, -1);
      else begin
        e = q.pop_front();
        check(e.kind == k && e.d == d, "R4/R5/R6/R7 strobe kind*256+data", k*256+d, e.kind*256+e.d);
      end
    end
  end

  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_oe !== oe_prev && scl_m) r10_viol++;
    oe_prev <= sda_oe;
  end

  task automatic hw; repeat (H) @(negedge clk); endtask
  task automatic i2c_start;
    sda_m_low = 0; hw; scl_m = 1; hw; sda_m_low = 1; hw; scl_m = 0; hw;
  endtask
  task automatic i2c_stop;
    sda_m_low = 1; hw; scl_m = 1; hw; sda_m_low = 0; hw; hw;
  endtask
  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m_low = ~b[i]; hw; scl_m = 1; hw; scl_m = 0;
    end
    sda_m_low = 0; hw; scl_m = 1; hw; ack = ~sda_line; scl_m = 0; hw;
  endtask
  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_m_low = 0;
    for (int i = 0; i < 8; i++) begin
      hw; scl_m = 1; hw; b = {b[6:0], sda_line}; scl_m = 0;
    end
    sda_m_low = give_ack; hw; scl_m = 1; hw; scl_m = 0; hw; sda_m_low = 0;
  endtask

  task automatic finish_all;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_all();
  end

  initial begin
    bit ack; logic [7:0] b;
    repeat (5) @(negedge clk); rst_n = 1; hw;
    check(sda_oe == 0 && !(ptr_load|wbuf_push|ptr_inc|wr_launch), "R1 reset outputs", sda_oe, 0);

    // Write: pointer 0x10 then two data bytes
    expect_ev(0, 8'h10); expect_ev(1, 8'hA5); expect_ev(1, 8'h3C); expect_ev(3, 8'h00);
    i2c_start();
    send_byte({DEV, 1'b0}, ack); check(ack, "R2 address ack", ack, 1);
    send_byte(8'h10, ack);        check(ack, "R4 pointer ack", ack, 1);
    send_byte(8'hA5, ack);        check(ack, "R5 data ack", ack, 1);
    send_byte(8'h3C, ack);        check(ack, "R5 data ack 2", ack, 1);
    i2c_stop(); hw;
    check(q.size() == 0, "R6 launch seen", q.size(), 0);

    // Busy: address refused
    busy = 1;
    i2c_start();
    send_byte({DEV, 1'b0}, ack); check(!ack, "R3 busy nack", ack, 0);
    send_byte(8'h33, ack);       check(!ack, "R3 ignored byte", ack, 0);
    i2c_stop(); busy = 0;

    // Neighbouring address: ignored
    i2c_start();
    send_byte({DEV ^ 7'h01, 1'b0}, ack); check(!ack, "R2 mismatch nack", ack, 0);
    send_byte(8'h77, ack);               check(!ack, "R2 ignored byte", ack, 0);
    i2c_stop();

    // Selective read from 0x20, three bytes
    expect_ev(0, 8'h20); expect_ev(2, 8'h00); expect_ev(2, 8'h00); expect_ev(2, 8'h00);
    i2c_start();
    send_byte({DEV, 1'b0}, ack); check(ack, "R9 address ack", ack, 1);
    send_byte(8'h20, ack);       check(ack, "R9 pointer ack", ack, 1);
    i2c_start();
    send_byte({DEV, 1'b1}, ack); check(ack, "R9 read address ack", ack, 1);
    recv_byte(1, b); check(b == mem_f(8'h20), "R7 first read byte", b, mem_f(8'h20));
    recv_byte(1, b); check(b == mem_f(8'h21), "R8 continued byte", b, mem_f(8'h21));
    recv_byte(0, b); check(b == mem_f(8'h22), "R8 last byte", b, mem_f(8'h22));
    for (int i = 0; i < 9; i++) begin
      hw; scl_m = 1; hw;
      check(sda_line == 1, "R8 released after nack", sda_line, 1);
      scl_m = 0;
    end
    hw; i2c_stop();

    // Address-only write then STOP: pointer loads, no launch
    expect_ev(0, 8'h40);
    i2c_start();
    send_byte({DEV, 1'b0}, ack); check(ack, "R6 address ack", ack, 1);
    send_byte(8'h40, ack);       check(ack, "R6 pointer ack", ack, 1);
    i2c_stop(); hw;
    check(q.size() == 0, "R6 no launch", q.size(), 0);

    // Current-address read
    expect_ev(2, 8'h00);
    i2c_start();
    send_byte({DEV, 1'b1}, ack); check(ack, "R7 read address ack", ack, 1);
    recv_byte(0, b); check(b == mem_f(8'h40), "R7 current address byte", b, mem_f(8'h40));
    i2c_stop(); hw;

    check(q.size() == 0, "R7 scoreboard drained", q.size(), 0);
    check(r10_viol == 0, "R10 drive changes while SCL high", r10_viol, 0);
    finish_all();
  end
endmodule